// File: doc/BRIEF.md
# DMA Stream FIFO with Burst Packing

This block is the buffering stage of a single DMA stream that moves data from memory to a peripheral. It fetches 32-bit words on a memory-side port and hands them to the peripheral one byte, one halfword or one word at a time. It holds a 64-byte ring of storage. Reads from memory are grouped into incrementing bursts of 1, 4, 8 or 16 beats. One request/grant handshake opens each burst, and no further arbitration happens until its last beat has arrived.

Software sets up a transfer with a start address, a byte count, a burst length, a refill threshold and a peripheral width, then pulses `start`. The block asks for a new burst only when two things are true. First, the fill level must have drained to the chosen quarter of capacity or below. Second, the free space must hold the whole burst. If fewer words remain than one burst holds, the rest are fetched as single beats. If a burst would cross a 1 KB address boundary, the block sets an error flag and stops fetching. It still drains what it already holds. It reports its fill level in bytes at all times.

Top module: `dmaf_stream`

## Requirements
- R1: After a synchronous reset, `mem_req`, `per_valid`, `refill_req`, `busy` and `err` are 0 and `fill_level` is 0.
- R2: The burst select code gives the beats per burst: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 16. While at least that many words remain to be fetched, `mem_beats` at grant equals that length.
- R3: When fewer words remain than one burst holds, each remaining word is requested as a 1-beat burst. The total number of beats delivered is the byte count divided by 4.
- R4: A burst is requested only when the free space (64 minus `fill_level`) is at least 4 times its beat count. `fill_level` never exceeds 64.
- R5: Once raised, `mem_req` stays high with `mem_addr` and `mem_beats` unchanged until `mem_gnt` is sampled. The address at each grant is the start address plus the bytes already fetched.
- R6: The threshold code gives a level in bytes: 0 gives 16, 1 gives 32, 2 gives 48 and 3 gives 64. `refill_req` is 1 exactly when a transfer has bytes left to fetch, `err` is 0, and `fill_level` is at or below that level. `mem_req` rises only in the cycle after `refill_req` was 1.
- R7: The peripheral width code is 0 for byte, 1 for halfword and 2 for word. `per_data` carries the next bytes in ascending address order, with the lowest address in bits 7:0, and the unused upper bits are zero.
- R8: `per_valid` is 1 exactly when `fill_level` is at least the peripheral width in bytes. A handshake with `per_ready` removes that many bytes.
- R9: `fill_level` rises by 4 one edge after each accepted memory beat. It falls by the peripheral width one edge after each peripheral handshake.
- R10: If the low 10 address bits plus 4 times the pending beat count exceed 1024, `err` goes to 1. No request is issued for that burst and fetching stops. A burst that ends exactly on the boundary is legal. `err` clears on the next accepted `start`.
- R11: `start` is ignored while `busy` is 1. `busy` falls once every byte has been fetched (or fetching has stopped on error) and the FIFO is empty.
- R12: A 128-byte transfer with 4-beat bursts takes exactly 8 grants and 32 beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer with the configuration inputs (used only when idle) |
| cfg_addr | input | 32 | Word-aligned memory start address |
| cfg_bytes | input | 16 | Transfer length in bytes, a multiple of 4 |
| cfg_burst | input | 2 | Burst length code |
| cfg_thresh | input | 2 | Refill threshold code |
| cfg_psize | input | 2 | Peripheral width code |
| mem_req | output | 1 | Burst request, held until granted |
| mem_addr | output | 32 | Burst start address while requesting, then the current beat address |
| mem_beats | output | 5 | Beat count of the requested burst |
| mem_gnt | input | 1 | Grant for the pending burst |
| mem_rvalid | input | 1 | A read beat is on `mem_rdata` |
| mem_rdata | input | 32 | Read beat data, byte at the lowest address in bits 7:0 |
| per_valid | output | 1 | Peripheral data available |
| per_data | output | 32 | Peripheral data, right-aligned |
| per_ready | input | 1 | Peripheral takes `per_data` |
| fill_level | output | 7 | Bytes held in the FIFO |
| refill_req | output | 1 | FIFO at or below the threshold with data still to fetch |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | A burst would have crossed a 1 KB boundary |

## Verification
The effect of each accepted memory beat or peripheral handshake shows up in `fill_level` and `per_valid` one clock edge later. `refill_req` follows `fill_level` combinationally. `mem_req` rises one edge after the cycle in which the refill and free-space conditions held. `err` is set one edge after a crossing is evaluated, and `busy` falls one edge after the FIFO empties with nothing left to fetch. The bench drives and samples on falling edges. It keeps a running model of the level and the bytes left, and updates that model with the actions it issued in the previous cycle before it compares. Peripheral data and grant contents are checked in the same half cycle in which the handshake is committed, because the outputs do not change until the following rising edge.

// File: rtl/dmaf_pkg.sv
package dmaf_pkg;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int WORD_B = 4;
    localparam int WORD_W = 8 * WORD_B;
    localparam int BEAT_W = 5;
    localparam int SZ_W   = 3;

    typedef enum logic [1:0] {
        BL_SINGLE = 2'd0,
        BL_INCR4  = 2'd1,
        BL_INCR8  = 2'd2,
        BL_INCR16 = 2'd3
    } burst_e;

    typedef enum logic [1:0] {
        TH_QUARTER  = 2'd0,
        TH_HALF     = 2'd1,
        TH_3QUARTER = 2'd2,
        TH_FULL     = 2'd3
    } thresh_e;

    typedef enum logic [1:0] {
        PS_BYTE = 2'd0,
        PS_HALF = 2'd1,
        PS_WORD = 2'd2,
        PS_RSVD = 2'd3
    } psize_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_REQ   = 2'd2,
        ST_BURST = 2'd3
    } fetch_st_e;

    typedef struct packed {
        burst_e  burst;
        thresh_e thresh;
        psize_e  psize;
    } stream_cfg_t;

    function automatic logic [BEAT_W-1:0] burst_beats(input burst_e b);
        case (b)
            BL_INCR4:  return BEAT_W'(4);
            BL_INCR8:  return BEAT_W'(8);
            BL_INCR16: return BEAT_W'(16);
            default:   return BEAT_W'(1);
        endcase
    endfunction

    function automatic logic [SZ_W-1:0] psize_bytes(input psize_e p);
        case (p)
            PS_BYTE: return SZ_W'(1);
            PS_HALF: return SZ_W'(2);
            default: return SZ_W'(4);
        endcase
    endfunction

    function automatic logic [31:0] thresh_level(input thresh_e t, input int unsigned depth_b);
        return 32'((depth_b * (int'(t) + 1)) / 4);
    endfunction

endpackage

// File: rtl/dmaf_ring.sv
module dmaf_ring import dmaf_pkg::*; #(
    parameter  int DEPTH_B = 64,
    localparam int PW      = $clog2(DEPTH_B),
    localparam int LVL_W   = $clog2(DEPTH_B + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic [SZ_W-1:0]   pop_n,
    output logic [WORD_W-1:0] head_word,
    output logic [LVL_W-1:0]  level
);

    logic [7:0]    store [DEPTH_B];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    // Byte lanes of an incoming word land at consecutive ring slots.
    always_ff @(posedge clk) begin
        if (push) begin
            for (int i = 0; i < WORD_B; i++) begin
                store[wr_ptr + PW'(i)] <= push_word[8*i +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + PW'(WORD_B);
            end
            rd_ptr <= rd_ptr + PW'(pop_n);
            level  <= level + (push ? LVL_W'(WORD_B) : LVL_W'(0)) - LVL_W'(pop_n);
        end
    end

    generate
        for (genvar g = 0; g < WORD_B; g++) begin : g_head
            assign head_word[8*g +: 8] = store[rd_ptr + PW'(g)];
        end
    endgenerate

endmodule

// File: rtl/dmaf_unpack.sv
module dmaf_unpack import dmaf_pkg::*; #(
    parameter int LVL_W = 7
) (
    input  logic [WORD_W-1:0] head_word,
    input  logic [LVL_W-1:0]  level,
    input  psize_e            psize,
    input  logic              per_ready,
    output logic              per_valid,
    output logic [WORD_W-1:0] per_data,
    output logic [SZ_W-1:0]   pop_n
);

    logic [SZ_W-1:0] sz;

    assign sz        = psize_bytes(psize);
    assign per_valid = 32'(level) >= 32'(sz);
    assign pop_n     = (per_valid && per_ready) ? sz : SZ_W'(0);

    // Lowest-addressed byte sits in lane 0; lanes beyond the width read zero.
    generate
        for (genvar g = 0; g < WORD_B; g++) begin : g_lane
            assign per_data[8*g +: 8] = (SZ_W'(g) < sz) ? head_word[8*g +: 8] : 8'h00;
        end
    endgenerate

endmodule

// File: rtl/dmaf_burst_ctl.sv
module dmaf_burst_ctl import dmaf_pkg::*; #(
    parameter  int DEPTH_B = 64,
    parameter  int BOUND_B = 1024,
    localparam int LVL_W   = $clog2(DEPTH_B + 1),
    localparam int BOFF_W  = $clog2(BOUND_B)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_bytes,
    input  burst_e            burst,
    input  thresh_e           thresh,
    input  logic [LVL_W-1:0]  level,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BEAT_W-1:0] mem_beats,
    output logic              beat_take,
    output logic              refill_req,
    output logic              busy,
    output logic              err
);

    fetch_st_e         state;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;
    logic [BEAT_W-1:0] beats_q;
    logic [BEAT_W-1:0] cnt_q;
    logic              err_q;

    logic [BEAT_W-1:0] bl;
    logic [BEAT_W-1:0] beats_n;
    logic [31:0]       need_b;
    logic [31:0]       free_b;
    logic [31:0]       end_off;
    logic              crosses;
    logic              drained;

    always_comb begin
        bl      = burst_beats(burst);
        beats_n = (32'(left_q >> 2) >= 32'(bl)) ? bl : BEAT_W'(1);
        need_b  = 32'(beats_n) << 2;
        free_b  = 32'(DEPTH_B) - 32'(level);
        end_off = 32'(addr_q[BOFF_W-1:0]) + need_b;
        crosses = end_off > 32'(BOUND_B);
        drained = (left_q == '0) || err_q;
    end

    assign refill_req = (state != ST_IDLE) && !drained
                        && (32'(level) <= thresh_level(thresh, DEPTH_B));
    assign mem_req    = (state == ST_REQ);
    assign mem_addr   = addr_q;
    assign mem_beats  = beats_q;
    assign beat_take  = (state == ST_BURST) && mem_rvalid;
    assign busy       = (state != ST_IDLE);
    assign err        = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            left_q  <= '0;
            beats_q <= '0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_WAIT;
                        addr_q <= start_addr;
                        left_q <= start_bytes;
                        err_q  <= 1'b0;
                    end
                end
                ST_WAIT: begin
                    if (drained) begin
                        if (level == '0) begin
                            state <= ST_IDLE;
                        end
                    end else if (crosses) begin
                        err_q <= 1'b1;
                    end else if (refill_req && (free_b >= need_b)) begin
                        state   <= ST_REQ;
                        beats_q <= beats_n;
                    end
                end
                ST_REQ: begin
                    if (mem_gnt) begin
                        state <= ST_BURST;
                        cnt_q <= beats_q;
                    end
                end
                ST_BURST: begin
                    if (mem_rvalid) begin
                        addr_q <= addr_q + ADDR_W'(WORD_B);
                        left_q <= left_q - CNT_W'(WORD_B);
                        cnt_q  <= cnt_q - BEAT_W'(1);
                        if (cnt_q == BEAT_W'(1)) begin
                            state <= ST_WAIT;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dmaf_stream.sv
module dmaf_stream import dmaf_pkg::*; #(
    parameter  int DEPTH_WORDS = 16,
    parameter  int BOUND_B     = 1024,
    localparam int DEPTH_B     = DEPTH_WORDS * WORD_B,
    localparam int LVL_W       = $clog2(DEPTH_B + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_bytes,
    input  logic [1:0]        cfg_burst,
    input  logic [1:0]        cfg_thresh,
    input  logic [1:0]        cfg_psize,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BEAT_W-1:0] mem_beats,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              per_valid,
    output logic [WORD_W-1:0] per_data,
    input  logic              per_ready,
    output logic [LVL_W-1:0]  fill_level,
    output logic              refill_req,
    output logic              busy,
    output logic              err
);

    stream_cfg_t       cfg_q;
    logic              beat_take;
    logic [WORD_W-1:0] head_word;
    logic [SZ_W-1:0]   pop_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{burst: BL_SINGLE, thresh: TH_QUARTER, psize: PS_BYTE};
        end else if (start && !busy) begin
            cfg_q <= '{burst:  burst_e'(cfg_burst),
                       thresh: thresh_e'(cfg_thresh),
                       psize:  psize_e'(cfg_psize)};
        end
    end

    dmaf_burst_ctl #(
        .DEPTH_B (DEPTH_B),
        .BOUND_B (BOUND_B)
    ) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_addr  (cfg_addr),
        .start_bytes (cfg_bytes),
        .burst       (cfg_q.burst),
        .thresh      (cfg_q.thresh),
        .level       (fill_level),
        .mem_gnt     (mem_gnt),
        .mem_rvalid  (mem_rvalid),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_beats   (mem_beats),
        .beat_take   (beat_take),
        .refill_req  (refill_req),
        .busy        (busy),
        .err         (err)
    );

    dmaf_ring #(
        .DEPTH_B (DEPTH_B)
    ) u_ring (
        .clk       (clk),
        .rst       (rst),
        .push      (beat_take),
        .push_word (mem_rdata),
        .pop_n     (pop_n),
        .head_word (head_word),
        .level     (fill_level)
    );

    dmaf_unpack #(
        .LVL_W (LVL_W)
    ) u_unpack (
        .head_word (head_word),
        .level     (fill_level),
        .psize     (cfg_q.psize),
        .per_ready (per_ready),
        .per_valid (per_valid),
        .per_data  (per_data),
        .pop_n     (pop_n)
    );

endmodule

// File: rtl/dmaf_stream_chk.sv
module dmaf_stream_chk import dmaf_pkg::*; #(
    parameter int DEPTH_B = 64,
    parameter int LVL_W   = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [BEAT_W-1:0] mem_beats,
    input logic              per_valid,
    input logic [LVL_W-1:0]  fill_level,
    input logic              refill_req,
    input logic              err,
    input psize_e            psize_q
);

    // R4: storage is never overfilled
    a_r4_level_bound: assert property (@(posedge clk) disable iff (rst)
        32'(fill_level) <= 32'(DEPTH_B));

    // R5: a pending request keeps its address and length until granted
    a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_beats)));

    // R6: a request is raised only after the refill condition held
    a_r6_req_after_refill: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> $past(refill_req));

    // R8: peripheral data is offered only when enough bytes are held
    a_r8_valid_level: assert property (@(posedge clk) disable iff (rst)
        per_valid |-> (32'(fill_level) >= 32'(psize_bytes(psize_q))));

    // R10: no request while the boundary error stands
    a_r10_err_no_req: assert property (@(posedge clk) disable iff (rst)
        err |-> !mem_req);

endmodule

bind dmaf_stream dmaf_stream_chk #(
    .DEPTH_B (DEPTH_B),
    .LVL_W   (LVL_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_req    (mem_req),
    .mem_gnt    (mem_gnt),
    .mem_addr   (mem_addr),
    .mem_beats  (mem_beats),
    .per_valid  (per_valid),
    .fill_level (fill_level),
    .refill_req (refill_req),
    .err        (err),
    .psize_q    (cfg_q.psize)
);

// File: tb/dmaf_stream_tb.sv
`timescale 1ns/1ps
module dmaf_stream_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] cfg_addr;
    logic [15:0] cfg_bytes;
    logic [1:0]  cfg_burst;
    logic [1:0]  cfg_thresh;
    logic [1:0]  cfg_psize;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [4:0]  mem_beats;
    logic        mem_gnt;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        per_valid;
    logic [31:0] per_data;
    logic        per_ready;
    logic [6:0]  fill_level;
    logic        refill_req;
    logic        busy;
    logic        err;

    always #10 clk = ~clk;

    dmaf_stream u_dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cfg_addr   (cfg_addr),
        .cfg_bytes  (cfg_bytes),
        .cfg_burst  (cfg_burst),
        .cfg_thresh (cfg_thresh),
        .cfg_psize  (cfg_psize),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_beats  (mem_beats),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .per_valid  (per_valid),
        .per_data   (per_data),
        .per_ready  (per_ready),
        .fill_level (fill_level),
        .refill_req (refill_req),
        .busy       (busy),
        .err        (err)
    );

    int checks = 0;
    int errors = 0;
    int ngrant;
    int nbeat;
    int nsent;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] patb(input logic [31:0] a);
        logic [31:0] t;
        t = a * 32'd29 + 32'd11;
        return t[7:0];
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = patb(a + 32'(i));
        return r;
    endfunction

    // R7: bytes in ascending address order, lowest in lane 0, upper lanes zero
    function automatic logic [31:0] exp_data(input logic [31:0] a, input int sz);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < sz; i++) r[8*i +: 8] = patb(a + 32'(i));
        return r;
    endfunction

    task automatic run_xfer(input logic [31:0] a, input int nbytes, input logic [1:0] bsel,
                            input logic [1:0] tsel, input logic [1:0] psel,
                            input int gpct, input int rpct, input bit poke, input bit want_err);
        int szb;
        int blen;
        int thr;
        int model_lvl;
        int model_left;
        int pending;
        logic [31:0] beat_addr;
        bit rv_prev;
        bit hs_prev;
        bit rv;
        bit hs;
        int cyc;
        szb  = (psel == 2'd0) ? 1 : (psel == 2'd1) ? 2 : 4;
        blen = (bsel == 2'd0) ? 1 : (4 << (int'(bsel) - 1));
        thr  = 16 * (int'(tsel) + 1);
        @(negedge clk);
        cfg_addr = a; cfg_bytes = 16'(nbytes); cfg_burst = bsel;
        cfg_thresh = tsel; cfg_psize = psel; start = 1'b1;
        model_lvl = 0; model_left = nbytes; pending = 0; beat_addr = '0;
        ngrant = 0; nbeat = 0; nsent = 0; rv_prev = 0; hs_prev = 0; cyc = 0;
        @(negedge clk);
        start = 1'b0;
        while (cyc < 6000) begin
            model_lvl = model_lvl + (rv_prev ? 4 : 0) - (hs_prev ? szb : 0);
            if (rv_prev) model_left = model_left - 4;
            chk(int'(fill_level) == model_lvl, "R9 fill_level", fill_level, model_lvl);
            if (!want_err)
                chk(refill_req == ((model_left > 0) && (model_lvl <= thr)), "R6 refill_req",
                    refill_req, (model_left > 0) && (model_lvl <= thr));
            if (!busy) break;
            if (poke && cyc == 4) begin
                start = 1'b1; cfg_addr = a ^ 32'h100; cfg_bytes = 16'd4; cfg_psize = 2'd2;
            end else begin
                start = 1'b0; cfg_addr = a; cfg_bytes = 16'(nbytes); cfg_psize = psel;
            end
            rv = (pending > 0) && (($urandom % 100) < 70);
            mem_rvalid = rv;
            mem_rdata  = rv ? mem_word(beat_addr) : 32'hdead_beef;
            if (rv) begin
                pending--; beat_addr = beat_addr + 32'd4; nbeat++;
            end
            if (mem_req && pending == 0 && !rv && (($urandom % 100) < gpct)) begin
                int wl;
                int eb;
                wl = model_left / 4;
                eb = (wl >= blen) ? blen : 1;
                chk(int'(mem_beats) == eb, "R2 R3 beats at grant", mem_beats, eb);
                chk(mem_addr == a + 32'(nbytes - model_left), "R5 grant address",
                    mem_addr, a + 32'(nbytes - model_left));
                chk(4 * int'(mem_beats) <= 64 - model_lvl, "R4 space for burst",
                    4 * int'(mem_beats), 64 - model_lvl);
                pending = int'(mem_beats); beat_addr = mem_addr; ngrant++;
                mem_gnt = 1'b1;
            end else begin
                mem_gnt = 1'b0;
            end
            per_ready = (($urandom % 100) < rpct);
            chk(per_valid == (model_lvl >= szb), "R8 per_valid", per_valid, model_lvl >= szb);
            hs = per_ready && per_valid;
            if (hs) begin
                chk(per_data == exp_data(a + 32'(nsent), szb), "R7 per_data",
                    per_data, exp_data(a + 32'(nsent), szb));
                nsent = nsent + szb;
            end
            rv_prev = rv; hs_prev = hs; cyc++;
            @(negedge clk);
        end
        start = 1'b0; mem_gnt = 1'b0; mem_rvalid = 1'b0; per_ready = 1'b0;
        chk(!busy, "R11 busy clears", busy, 0);
        if (want_err) begin
            chk(err == 1'b1, "R10 boundary error", err, 1);
            chk(ngrant == 0, "R10 no grant after crossing", ngrant, 0);
        end else begin
            chk(err == 1'b0, "R10 no error", err, 0);
            chk(nbeat * 4 == nbytes, "R3 total beats", nbeat, nbytes / 4);
            chk(nsent == nbytes, "R11 all bytes delivered", nsent, nbytes);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; start = 1'b0; cfg_addr = '0; cfg_bytes = '0; cfg_burst = '0;
        cfg_thresh = '0; cfg_psize = '0; mem_gnt = 1'b0; mem_rvalid = 1'b0;
        mem_rdata = '0; per_ready = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!mem_req && !per_valid && !refill_req && !busy && !err, "R1 reset outputs",
            {mem_req, per_valid, refill_req, busy, err}, 0);
        chk(fill_level == 7'd0, "R1 reset level", fill_level, 0);

        // R12: 128 bytes, 4-beat bursts, byte peripheral
        run_xfer(32'h0000_1000, 128, 2'd1, 2'd1, 2'd0, 100, 100, 0, 0);
        chk(ngrant == 8, "R12 grant count", ngrant, 8);
        chk(nbeat == 32, "R12 beat count", nbeat, 32);

        // R3: tail shorter than a burst falls back to single beats
        run_xfer(32'h0000_2000, 24, 2'd1, 2'd3, 2'd1, 80, 60, 0, 0);
        chk(ngrant == 3, "R3 grants 4+1+1", ngrant, 3);

        // R2 and R11: 8-beat bursts, start poked mid-transfer
        run_xfer(32'h0000_3000, 64, 2'd2, 2'd1, 2'd2, 90, 50, 1, 0);
        chk(ngrant == 2, "R2 eight-beat grants", ngrant, 2);

        // R10 edge: 16-beat burst ending exactly on the boundary is legal
        run_xfer(32'h0000_03C0, 64, 2'd3, 2'd0, 2'd2, 100, 100, 0, 0);
        chk(ngrant == 1, "R10 burst ending on boundary", ngrant, 1);

        // R10: 16-beat burst that would cross the boundary
        run_xfer(32'h0000_03F0, 128, 2'd3, 2'd0, 2'd0, 100, 100, 0, 1);

        // R2: single-beat mode, full threshold; also R10 err cleared by new start
        run_xfer(32'h0000_5000, 16, 2'd0, 2'd3, 2'd0, 100, 40, 0, 0);
        chk(ngrant == 4, "R2 single-beat grants", ngrant, 4);

        // random mix, addresses aligned so no burst crosses a boundary
        for (int n = 0; n < 10; n++) begin
            logic [31:0] ra;
            ra = {$urandom % 32'h4000, 6'b0};
            run_xfer(ra, 4 * (1 + int'($urandom % 48)), 2'($urandom % 4), 2'($urandom % 4),
                     2'($urandom % 3), 30 + int'($urandom % 71), 20 + int'($urandom % 81), 0, 0);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule